// File: doc/BRIEF.md
# CAN Test-Mode Bus Path Controller

This block sits between a CAN protocol engine and the transceiver pins and reroutes the transmit and receive bit paths for self-test and bus-monitoring. It holds a small test-mode register that the host can write only while a master test-enable input is high. That input gates every mode; dropping it returns the path to normal operation at once and clears the register on the next clock.

Three path modes can be selected. In the listen-only mode the transmit pin stays recessive and the engine is blocked from starting frames, yet it still sees its own dominant bits. In the internal-echo mode the engine's transmit bit is fed straight back to its receive input, the pin is ignored and the engine is told to mask acknowledge errors. The two can be combined for a fully internal self-test. A two-bit pin-drive field can also override the transmit pin: force dominant, force recessive, or show the sample-point strobe. A synchronised copy of the receive pin is always available for readback.

Top module: `can_test_path`

## Requirements
- R1: The mode register is loaded from `wr_data` on a clock edge where `wr_en` and `test_en` are both 1, and it keeps its value when `wr_en` is 0. Field layout of `wr_data` and `mode_q`: bit 0 = basic, bit 1 = listen-only, bit 2 = internal echo, bits 4:3 = pin-drive field. After reset `mode_q` is 0.
- R2: While `test_en` is 0, `tx_pin` equals `core_tx`, `core_rx` equals `rx_pin`, `ack_ign`, `tx_block` and `basic_mode` are 0 in the same cycle. `mode_q` reads 0 from the edge after `test_en` is sampled 0, and writes are ignored.
- R3: `rx_mon` equals `rx_pin` as sampled `MON_STAGES` rising edges earlier (all stages reset to 1); with `MON_STAGES` = 0 it follows `rx_pin` directly.
- R4: Listen-only alone (test on, listen-only 1, echo 0): `tx_pin` is 1 when the pin-drive field is 00, `core_rx` = `rx_pin` AND `core_tx`, and `tx_block` is 1.
- R5: Internal echo alone: `core_rx` = `core_tx` whatever `rx_pin` is, and `tx_pin` = `core_tx` when the pin-drive field is 00.
- R6: `ack_ign` is 1 exactly when test is on and internal echo is set.
- R7: Listen-only and echo together: `core_rx` = `core_tx`, `tx_pin` is 1 when the pin-drive field is 00, and `tx_block` is 1.
- R8: With test on, a pin-drive field of 01 drives `tx_pin` with `sample_pt`, 10 drives 0, 11 drives 1, overriding listen-only and echo pin drive; receive routing is unaffected.
- R9: `basic_mode` is 1 exactly when test is on and the basic bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Master test enable |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 5 | Mode register write value |
| core_tx | input | 1 | Transmit bit from the protocol engine |
| sample_pt | input | 1 | Sample-point strobe from bit timing |
| rx_pin | input | 1 | Receive pin from the transceiver |
| tx_pin | output | 1 | Transmit pin to the transceiver |
| core_rx | output | 1 | Receive bit given to the protocol engine |
| rx_mon | output | 1 | Synchronised receive-pin monitor |
| ack_ign | output | 1 | Tells the engine to mask acknowledge errors |
| tx_block | output | 1 | Tells the engine not to start a frame |
| basic_mode | output | 1 | Basic mode active |
| mode_q | output | 5 | Mode register readback |

## Verification
The bench builds the block with `MON_STAGES` = 2, the default, so the monitor is checked against a two-deep history of the receive pin including the recessive values that fill it after reset. Random stimulus with the test enable held high most of the time reaches every combination of listen-only, echo and the four pin-drive codes, while occasional drops of the enable exercise the same-cycle return to the normal path and the clearing on the next edge.

// File: rtl/can_tm_pkg.sv
package can_tm_pkg;
   localparam int MODE_W = 5;

   typedef enum logic [1:0] {
      PIN_CORE   = 2'b00,
      PIN_SAMPLE = 2'b01,
      PIN_DOM    = 2'b10,
      PIN_REC    = 2'b11
   } pin_drive_e;

   typedef struct packed {
      pin_drive_e pin;
      logic       echo;
      logic       listen;
      logic       basic;
   } tm_mode_t;

   localparam logic RECESSIVE = 1'b1;
   localparam logic DOMINANT  = 1'b0;
endpackage

// File: rtl/can_tm_regs.sv
module can_tm_regs
   import can_tm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     test_en,
   input  logic     wr_en,
   input  tm_mode_t wr_val,
   output tm_mode_t mode_r,
   output tm_mode_t mode_eff
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= '0;
      end else if (!test_en) begin
         mode_r <= '0;
      end else if (wr_en) begin
         mode_r <= wr_val;
      end
   end

   always_comb begin
      mode_eff = test_en ? mode_r : '0;
   end
endmodule

// File: rtl/can_tm_rxmon.sv
module can_tm_rxmon #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic mon_out
);
   generate
      if (STAGES == 0) begin : g_direct
         assign mon_out = pin_in;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '1;
            end else if (STAGES == 1) begin
               chain <= pin_in;
            end else begin
               chain <= {chain[STAGES-2:0], pin_in};
            end
         end
         assign mon_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/can_tm_route.sv
module can_tm_route
   import can_tm_pkg::*;
(
   input  tm_mode_t mode_eff,
   input  logic     core_tx,
   input  logic     sample_pt,
   input  logic     rx_pin,
   output logic     tx_pin,
   output logic     core_rx,
   output logic     ack_ign,
   output logic     tx_block,
   output logic     basic_mode
);
   logic bus_drive;

   always_comb begin
      bus_drive = mode_eff.listen ? RECESSIVE : core_tx;
      unique case (mode_eff.pin)
         PIN_SAMPLE: tx_pin = sample_pt;
         PIN_DOM:    tx_pin = DOMINANT;
         PIN_REC:    tx_pin = RECESSIVE;
         default:    tx_pin = bus_drive;
      endcase
   end

   always_comb begin
      if (mode_eff.echo) begin
         core_rx = core_tx;
      end else if (mode_eff.listen) begin
         core_rx = rx_pin & core_tx;
      end else begin
         core_rx = rx_pin;
      end
   end

   assign ack_ign    = mode_eff.echo;
   assign tx_block   = mode_eff.listen;
   assign basic_mode = mode_eff.basic;
endmodule

// File: rtl/can_test_path.sv
module can_test_path
   import can_tm_pkg::*;
#(
   parameter int MON_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              test_en,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_data,
   input  logic              core_tx,
   input  logic              sample_pt,
   input  logic              rx_pin,
   output logic              tx_pin,
   output logic              core_rx,
   output logic              rx_mon,
   output logic              ack_ign,
   output logic              tx_block,
   output logic              basic_mode,
   output logic [MODE_W-1:0] mode_q
);
   localparam int MAX_STAGES = 8;

   initial begin
      if (MON_STAGES < 0 || MON_STAGES > MAX_STAGES)
         $fatal(1, "MON_STAGES out of range");
   end

   tm_mode_t mode_r;
   tm_mode_t mode_eff;

   can_tm_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .test_en  (test_en),
      .wr_en    (wr_en),
      .wr_val   (tm_mode_t'(wr_data)),
      .mode_r   (mode_r),
      .mode_eff (mode_eff)
   );

   can_tm_route u_route (
      .mode_eff   (mode_eff),
      .core_tx    (core_tx),
      .sample_pt  (sample_pt),
      .rx_pin     (rx_pin),
      .tx_pin     (tx_pin),
      .core_rx    (core_rx),
      .ack_ign    (ack_ign),
      .tx_block   (tx_block),
      .basic_mode (basic_mode)
   );

   can_tm_rxmon #(.STAGES(MON_STAGES)) u_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (rx_pin),
      .mon_out (rx_mon)
   );

   assign mode_q = mode_r;
endmodule

// File: rtl/can_test_path_chk.sv
module can_test_path_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       test_en,
   input logic       wr_en,
   input logic       core_tx,
   input logic       rx_pin,
   input logic       tx_pin,
   input logic       core_rx,
   input logic       ack_ign,
   input logic       tx_block,
   input logic       basic_mode,
   input logic [4:0] mode_q
);
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && !wr_en) |=> (mode_q == $past(mode_q))); // R1
   AST_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |=> (mode_q == 5'd0)); // R2
   AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> (tx_pin == core_tx && core_rx == rx_pin && !ack_ign && !tx_block)); // R2
   AST_LISTEN_REC: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode_q[1] && mode_q[4:3] == 2'b00) |-> tx_pin); // R4
   AST_ECHO_FEED: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode_q[2]) |-> (core_rx == core_tx)); // R5
   AST_ACK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode_q[2]) |-> ack_ign); // R6
   AST_FORCE_DOM: assert property (@(posedge clk) disable iff (!rst_n)
      (test_en && mode_q[4:3] == 2'b10) |-> !tx_pin); // R8
   AST_BASIC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !test_en |-> !basic_mode); // R9
endmodule

bind can_test_path can_test_path_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .test_en    (test_en),
   .wr_en      (wr_en),
   .core_tx    (core_tx),
   .rx_pin     (rx_pin),
   .tx_pin     (tx_pin),
   .core_rx    (core_rx),
   .ack_ign    (ack_ign),
   .tx_block   (tx_block),
   .basic_mode (basic_mode),
   .mode_q     (mode_q)
);

// File: tb/can_test_path_test.sv
module can_test_path_test;
   localparam int STG = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic test_en = 1'b0, wr_en = 1'b0, core_tx = 1'b1, sample_pt = 1'b0, rx_pin = 1'b1;
   logic [4:0] wr_data = '0;
   logic tx_pin, core_rx, rx_mon, ack_ign, tx_block, basic_mode;
   logic [4:0] mode_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [4:0] m_mode = '0;
   logic       hist[$];

   always #5 clk = ~clk;

   can_test_path #(.MON_STAGES(STG)) uut (
      .clk(clk), .rst_n(rst_n), .test_en(test_en), .wr_en(wr_en), .wr_data(wr_data),
      .core_tx(core_tx), .sample_pt(sample_pt), .rx_pin(rx_pin), .tx_pin(tx_pin),
      .core_rx(core_rx), .rx_mon(rx_mon), .ack_ign(ack_ign), .tx_block(tx_block),
      .basic_mode(basic_mode), .mode_q(mode_q)
   );

   task automatic chk(string req, string what, logic [4:0] act, logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      logic lis, ech, exp_tx, exp_rx;
      logic [1:0] pin;
      string rtx, rrx;
      lis = test_en && m_mode[1];
      ech = test_en && m_mode[2];
      pin = test_en ? m_mode[4:3] : 2'b00;
      if (pin == 2'b01)      begin exp_tx = sample_pt; rtx = "R8"; end
      else if (pin == 2'b10) begin exp_tx = 1'b0; rtx = "R8"; end
      else if (pin == 2'b11) begin exp_tx = 1'b1; rtx = "R8"; end
      else if (lis)          begin exp_tx = 1'b1; rtx = ech ? "R7" : "R4"; end
      else                   begin exp_tx = core_tx; rtx = ech ? "R5" : "R2"; end
      if (ech)      begin exp_rx = core_tx; rrx = lis ? "R7" : "R5"; end
      else if (lis) begin exp_rx = rx_pin & core_tx; rrx = "R4"; end
      else          begin exp_rx = rx_pin; rrx = "R2"; end
      chk(rtx, "tx_pin", tx_pin, exp_tx);
      chk(rrx, "core_rx", core_rx, exp_rx);
      chk("R6", "ack_ign", ack_ign, ech);
      chk(test_en ? "R4" : "R2", "tx_block", tx_block, lis);
      chk("R9", "basic_mode", basic_mode, test_en && m_mode[0]);
      chk("R1", "mode_q", mode_q, m_mode);
      chk("R3", "rx_mon", rx_mon, hist[STG-1]);
   endtask

   // one cycle: drive at negedge, compare, then advance the model at posedge
   task automatic cycle(logic te, logic we, logic [4:0] wd, logic ct, logic sp, logic rp);
      logic [4:0] nxt;
      @(negedge clk);
      test_en = te; wr_en = we; wr_data = wd; core_tx = ct; sample_pt = sp; rx_pin = rp;
      #1;
      compare();
      nxt = !te ? 5'd0 : (we ? wd : m_mode);
      @(posedge clk);
      m_mode = nxt;
      hist.push_front(rp);
      void'(hist.pop_back());
   endtask

   initial begin
      for (int i = 0; i < STG; i++) hist.push_back(1'b1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // reset state (R1, R3)
      chk("R1", "mode_q reset", mode_q, 5'd0);
      chk("R3", "rx_mon reset", rx_mon, 1'b1);
      rst_n = 1'b1;
      // R1: write rejected while test off
      cycle(1'b0, 1'b1, 5'h1f, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 5'h00, 1'b1, 1'b0, 1'b1);
      chk("R1", "write while off", mode_q, 5'd0);
      // R4 listen-only with dominant tx
      cycle(1'b1, 1'b1, 5'b00010, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
      // R5 echo, pin disagrees
      cycle(1'b1, 1'b1, 5'b00100, 1'b1, 1'b0, 1'b0);
      cycle(1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
      // R7 combined
      cycle(1'b1, 1'b1, 5'b00110, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b0);
      // R8 each pin code over listen+echo
      for (int c = 1; c < 4; c++) begin
         cycle(1'b1, 1'b1, {c[1:0], 3'b111}, 1'b0, 1'b1, 1'b1);
         cycle(1'b1, 1'b0, 5'h00, 1'b1, 1'b1, 1'b0);
         cycle(1'b1, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
      end
      // R2 drop test: immediate normal path, cleared next edge
      cycle(1'b0, 1'b0, 5'h00, 1'b0, 1'b0, 1'b1);
      cycle(1'b1, 1'b0, 5'h00, 1'b1, 1'b0, 1'b0);
      chk("R2", "cleared after drop", mode_q, 5'd0);
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         logic te, we;
         te = ($urandom_range(0, 15) != 0);
         we = ($urandom_range(0, 3) == 0);
         cycle(te, we, 5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule